// File: doc/BRIEF.md
# Single-Error-Correcting Syndrome Decoder

This block decodes short binary block codes whose parity-check matrix is fixed when the design is elaborated. A start strobe captures a received word. The block then forms one syndrome bit for each matrix row. If the syndrome is zero, the word is accepted unchanged. If it is not zero, the block looks for a codeword position whose matrix column equals the syndrome and inverts that bit.

When the decode finishes, the block raises a completion flag and a success flag. It also presents the upper data-length bits of the corrected word. When no single-bit flip explains the syndrome, completion is still reported, but success stays low and the data is the uncorrected upper bits.

The matrix, the codeword length and the data length are all parameters. The default is a code with six-bit codewords and three data bits.

Top module: `syndrome_sec_decoder`

## Requirements
- R1: Matrix row r, bit i pairs with codeword bit i (bit 0 is the LSB). Syndrome bit r is the XOR of the codeword bits at the positions where row r holds a one.
- R2: A start seen in the idle state latches codeIn on that clock edge. done stays low after the first and second following edges and is high after the third.
- R3: When the syndrome is zero, success is 1 and dataOut equals codeIn[CW_LEN-1 -: DATA_LEN].
- R4: When the syndrome equals the column of exactly one position, that bit is inverted, success is 1 and dataOut equals the upper DATA_LEN bits of the corrected word.
- R5: When the syndrome is nonzero and matches no column, success is 0 and dataOut equals the uncorrected upper DATA_LEN bits.
- R6: done, success and dataOut hold their values while the block waits after a decode. A start in that state begins a new decode, and done and success read 0 one edge later.
- R7: A start that arrives while a decode is in progress has no effect. Neither the captured word nor the completion timing changes.
- R8: A synchronous reset returns the block to idle with done, success and dataOut at 0, including a reset that arrives during a decode.
- R9: When several columns equal the syndrome, only the lowest-index matching position is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| codeIn | input | CW_LEN | Received codeword |
| start | input | 1 | Begins a decode when the block is idle or finished |
| done | output | 1 | High once a decode has finished, until the next start |
| success | output | 1 | High when the word was valid or was corrected |
| dataOut | output | DATA_LEN | Upper DATA_LEN bits of the corrected word |

## Verification
With the default matrix every column is distinct, so the lowest-index priority of R9 can never be seen from the ports of that instance. The bench therefore runs a second instance whose matrix has pairs of identical columns, and feeds it every stimulus the first instance gets. Uncorrectable syndromes come from double-bit errors that are injected on valid codewords found by random search. Starts that must be ignored are held high through the capture and check cycles.

// File: rtl/sec_dec_pkg.sv
package sec_dec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_CHECK   = 2'd2,
    ST_DONE    = 2'd3
  } decState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;   // latch incoming word, clear success
    logic evaluate;  // register syndrome
    logic commit;    // register corrected result and verdict
  } decStrobe_t;
endpackage

// File: rtl/sec_dec_ctrl.sv
module sec_dec_ctrl
  import sec_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output decStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  decState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateD = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        strobe.evaluate = 1'b1;
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        strobe.commit = 1'b1;
        stateD = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign busy = (stateQ == ST_CAPTURE) || (stateQ == ST_CHECK);
  assign done = (stateQ == ST_DONE);
endmodule

// File: rtl/sec_dec_datapath.sv
module sec_dec_datapath
  import sec_dec_pkg::*;
#(
  parameter int CW_LEN   = 6,
  parameter int DATA_LEN = 3,
  parameter int CHK_ROWS = 3,
  parameter logic [CHK_ROWS-1:0][CW_LEN-1:0] H_MATRIX = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  decStrobe_t          strobe,
  input  logic [CW_LEN-1:0]   codeIn,
  output logic [DATA_LEN-1:0] dataOut,
  output logic                success
);
  localparam int TOP_BIT = CW_LEN - 1;

  logic [CW_LEN-1:0]                 cwQ;
  logic [CHK_ROWS-1:0]               synD, synQ;
  logic [CW_LEN-1:0][CHK_ROWS-1:0]   colVec;
  logic [CW_LEN-1:0]                 flipMask;
  logic                              colHit;
  logic [CW_LEN-1:0]                 fixedWord;
  logic                              verdict;
  logic [DATA_LEN-1:0]               resQ;
  logic                              succQ;

  // transpose matrix into per-position columns
  for (genvar gi = 0; gi < CW_LEN; gi++) begin : g_col
    for (genvar gr = 0; gr < CHK_ROWS; gr++) begin : g_row
      assign colVec[gi][gr] = H_MATRIX[gr][gi];
    end
  end

  // one parity tree per matrix row
  for (genvar gr = 0; gr < CHK_ROWS; gr++) begin : g_syn
    assign synD[gr] = ^(cwQ & H_MATRIX[gr]);
  end

  // priority search, lowest index written last so it wins
  always_comb begin
    flipMask = '0;
    colHit   = 1'b0;
    for (int i = CW_LEN - 1; i >= 0; i--) begin
      if (colVec[i] == synQ) begin
        flipMask    = '0;
        flipMask[i] = 1'b1;
        colHit      = 1'b1;
      end
    end
  end

  always_comb begin
    if (synQ == '0) begin
      fixedWord = cwQ;
      verdict   = 1'b1;
    end else begin
      fixedWord = cwQ ^ flipMask;
      verdict   = colHit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwQ   <= '0;
      synQ  <= '0;
      resQ  <= '0;
      succQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        cwQ   <= codeIn;
        succQ <= 1'b0;
      end
      if (strobe.evaluate) synQ <= synD;
      if (strobe.commit) begin
        resQ  <= fixedWord[TOP_BIT -: DATA_LEN];
        succQ <= verdict;
      end
    end
  end

  assign dataOut = resQ;
  assign success = succQ;
endmodule

// File: rtl/syndrome_sec_decoder.sv
module syndrome_sec_decoder
  import sec_dec_pkg::*;
#(
  parameter int CW_LEN   = 6,
  parameter int DATA_LEN = 3,
  parameter int CHK_ROWS = 3,
  parameter logic [CHK_ROWS-1:0][CW_LEN-1:0] H_MATRIX =
    {6'b111100, 6'b001101, 6'b100110}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW_LEN-1:0]   codeIn,
  input  logic                start,
  output logic                done,
  output logic                success,
  output logic [DATA_LEN-1:0] dataOut
);
  decStrobe_t ctrlStrobe;
  logic       ctrlBusy;

  sec_dec_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (ctrlStrobe),
    .busy   (ctrlBusy),
    .done   (done)
  );

  sec_dec_datapath #(
    .CW_LEN   (CW_LEN),
    .DATA_LEN (DATA_LEN),
    .CHK_ROWS (CHK_ROWS),
    .H_MATRIX (H_MATRIX)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (ctrlStrobe),
    .codeIn  (codeIn),
    .dataOut (dataOut),
    .success (success)
  );
endmodule

// File: rtl/sec_dec_checker.sv
module sec_dec_checker #(
  parameter int DATA_LEN = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                success,
  input logic [DATA_LEN-1:0] dataOut
);
  AST_SUCCESS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    success |-> done); // R6
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)); // R2
  AST_BUSY_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && busy)); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(dataOut)); // R6
  AST_NO_SUCCESS_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !success); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && !success && !busy && dataOut == '0)); // R8
endmodule

bind syndrome_sec_decoder sec_dec_checker #(.DATA_LEN(DATA_LEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (ctrlBusy),
  .done    (done),
  .success (success),
  .dataOut (dataOut)
);

// File: tb/syndrome_sec_decoder_tb.sv
module syndrome_sec_decoder_tb;
  localparam logic [2:0][5:0] HA = {6'b111100, 6'b001101, 6'b100110};
  localparam logic [2:0][5:0] HB = {6'b110000, 6'b001100, 6'b000011};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] codeIn = '0;
  logic       start = 1'b0;
  logic       doneA, succA, doneB, succB;
  logic [2:0] dataA, dataB;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  syndrome_sec_decoder u_dut (
    .clk(clk), .rst(rst), .codeIn(codeIn), .start(start),
    .done(doneA), .success(succA), .dataOut(dataA));

  syndrome_sec_decoder #(.H_MATRIX(HB)) u_dut_dup (
    .clk(clk), .rst(rst), .codeIn(codeIn), .start(start),
    .done(doneB), .success(succB), .dataOut(dataB));

  function automatic logic [2:0] refSyn(input logic [2:0][5:0] h, input logic [5:0] w);
    logic [2:0] s;
    for (int r = 0; r < 3; r++) begin
      s[r] = 1'b0;
      for (int i = 0; i < 6; i++) s[r] = s[r] ^ (h[r][i] & w[i]);
    end
    return s;
  endfunction

  // returns {success, data}
  function automatic logic [3:0] refDecode(input logic [2:0][5:0] h, input logic [5:0] w);
    logic [2:0] s;
    logic [5:0] fixed;
    logic       ok;
    s = refSyn(h, w);
    fixed = w;
    ok = (s == 3'b0);
    if (!ok) begin
      for (int i = 0; i < 6; i++) begin
        if (!ok && {h[2][i], h[1][i], h[0][i]} == s) begin
          fixed[i] = ~fixed[i];
          ok = 1'b1;
        end
      end
    end
    return {ok, fixed[5:3]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [5:0] w);
    logic [3:0] e;
    e = refDecode(HA, w);
    if (refSyn(HA, w) == 3'b0) return "R1,R3";
    if (e[3]) return "R1,R4";
    return "R1,R5";
  endfunction

  task automatic checkResults(input logic [5:0] w);
    logic [3:0] ea, eb;
    ea = refDecode(HA, w);
    eb = refDecode(HB, w);
    chk({"done ", "R2"}, {7'b0, doneA}, 8'd1);
    chk({"success ", tagFor(w)}, {7'b0, succA}, {7'b0, ea[3]});
    chk({"data ", tagFor(w)}, {5'b0, dataA}, {5'b0, ea[2:0]});
    chk("dup success R9", {7'b0, succB}, {7'b0, eb[3]});
    chk("dup data R9", {5'b0, dataB}, {5'b0, eb[2:0]});
  endtask

  task automatic runDecode(input logic [5:0] w);
    @(negedge clk); codeIn = w; start = 1'b1;
    @(negedge clk); start = 1'b0; codeIn = ~w;
    chk("done low after first edge R2 R6", {7'b0, doneA}, 8'd0);
    chk("success cleared at start R6", {7'b0, succA}, 8'd0);
    @(negedge clk);
    chk("done low after second edge R2", {7'b0, doneA}, 8'd0);
    @(negedge clk);
    checkResults(w);
  endtask

  function automatic logic [5:0] validWord();
    logic [5:0] w;
    do w = 6'($urandom); while (refSyn(HA, w) != 3'b0);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [5:0] w, a, b;
    logic [3:0] e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("reset done R8", {7'b0, doneA}, 8'd0);
    chk("reset success R8", {7'b0, succA}, 8'd0);
    chk("reset data R8", {5'b0, dataA}, 8'd0);
    rst = 1'b0;
    @(negedge clk);

    // zero word and a valid word without errors
    runDecode(6'b000000);
    w = validWord();
    runDecode(w);

    // every single-bit error position on a valid word
    for (int i = 0; i < 6; i++) begin
      runDecode(w ^ (6'b1 << i));
    end

    // double error whose syndrome matches no column
    runDecode(6'b000011);
    chk("uncorrectable success R5", {7'b0, succA}, 8'd0);
    chk("uncorrectable data R5", {5'b0, dataA}, 8'd0);

    // duplicate columns: bit5 and bit4 errors both flip bit 4
    runDecode(6'b100000);
    chk("dup lowest index R9", {4'b0, succB, dataB}, 8'b0000_1110);

    // hold after done
    runDecode(6'b101010);
    e = refDecode(HA, 6'b101010);
    repeat (5) begin
      @(negedge clk);
      codeIn = 6'($urandom);
      chk("hold done R6", {7'b0, doneA}, 8'd1);
      chk("hold verdict R6", {4'b0, succA, dataA}, {4'b0, e});
    end

    // start during capture and check is ignored
    a = validWord() ^ 6'b000100;
    b = ~a;
    @(negedge clk); codeIn = a; start = 1'b1;
    @(negedge clk); codeIn = b;
    @(negedge clk); codeIn = b;
    chk("busy start ignored done R7", {7'b0, doneA}, 8'd0);
    @(negedge clk); start = 1'b0;
    chk("busy start timing R7", {7'b0, doneA}, 8'd1);
    e = refDecode(HA, a);
    chk("busy start word R7", {4'b0, succA, dataA}, {4'b0, e});
    @(negedge clk);
    chk("no restart after busy start R7", {7'b0, doneA}, 8'd1);

    // reset during a decode
    @(negedge clk); codeIn = 6'b111111; start = 1'b1;
    @(negedge clk); start = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("mid reset done R8", {7'b0, doneA}, 8'd0);
    chk("mid reset verdict R8", {4'b0, succA, dataA}, 8'd0);
    repeat (3) @(negedge clk);
    chk("mid reset stays idle R8", {7'b0, doneA}, 8'd0);

    // constrained random: valid words with 0, 1, 2 errors or raw words
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom % 4);
      w = validWord();
      case (kind)
        1: w = w ^ (6'b1 << ($urandom % 6));
        2: w = w ^ (6'b1 << ($urandom % 6)) ^ (6'b1 << ($urandom % 6));
        3: w = 6'($urandom);
        default: ;
      endcase
      runDecode(w);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule